// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a software-serviced watchdog that escalates in two steps. Once enabled, a counter advances by one every clock. When it reaches a programmable limit, the block records an expiry and restarts the count. The first expiry raises a timeout flag, which drives the interrupt line. If software does not service the watchdog before the next expiry, that second back-to-back expiry drives the fault line toward a fault collection unit.

The block only reports. It takes no reset or recovery action, and whatever happens after the fault line rises is decided downstream. To service the watchdog, software writes two fixed key values in order through a small write-only register port. A correct pair restarts the count from zero and cancels a pending first-stage expiry. The flag is cleared by writing a one to it, and the fault is cleared by reset or by an explicit clear write.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `irq_o` and `fault_o` are low, the watchdog is disabled, and the limit holds `LIMIT_RST`.
- R2: While enabled, the counter starts at zero and rises by one each clock. An expiry occurs on the clock after the count equals or exceeds the limit, so the period is limit+1 cycles. The count then restarts at zero.
- R3: An expiry with no earlier unserviced expiry pending sets the timeout flag (`irq_o` high) and leaves `fault_o` unchanged.
- R4: An expiry while a first-stage expiry is pending (no valid service in between) sets `fault_o` and also sets the flag.
- R5: A write of 0xA602 to the key register (address 2), followed by a write of 0xB480 as the very next key-register write, is a valid service. It restarts the count from zero and cancels the pending first stage. It does not clear the flag.
- R6: 0xB480 without an immediately preceding 0xA602 at the key register does not service. Any other key-register value also cancels a started sequence.
- R7: A write to the clear register (address 3) with bit 0 set clears the flag. An expiry on the same clock wins, and writing 0 to bit 0 has no effect.
- R8: `fault_o` is sticky. It drops only on reset or on a clear-register write with bit 1 set. Disabling the block or clearing only bit 0 leaves it high.
- R9: Bit 0 of the control register (address 1) is the enable. While it is low, the count holds at zero, the pending stage and the flag are cleared, no expiry occurs, and `fault_o` cannot rise.
- R10: Address 0 loads the limit from the low `CNT_W` bits of the write data, and the new limit takes effect for the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 limit, 1 control, 2 key, 3 clear |
| wr_data | input | DATA_W | Write data |
| irq_o | output | 1 | Timeout flag / interrupt request (registered) |
| fault_o | output | 1 | Second-expiry fault indication (registered) |

## Verification
The bench builds the block with `CNT_W` = 8 and `LIMIT_RST` = 20, with the data width and keys left at their defaults. The short counter makes both the reset limit and a reprogrammed limit of 7 expire within a few dozen cycles. Several two-stage escalations, services placed between stages, a flag clear that lands on the same clock as an expiry, and long disabled stretches therefore all fit in a few hundred cycles. Every expected output is tied to an absolute cycle counted from the write that caused it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LIMIT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_KEY   = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CLR_FLAG_BIT  = 0;
  localparam int CLR_FAULT_BIT = 1;

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_A  = DATA_W'(16'hA602),
  parameter logic [DATA_W-1:0] KEY_B  = DATA_W'(16'hB480)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              svc_o
);

  logic armed_q;

  // Only the next key-register write can complete a sequence.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (!en) begin
      armed_q <= 1'b0;
    end else if (key_wr) begin
      armed_q <= (key_data == KEY_A);
    end
  end

  assign svc_o = en && key_wr && armed_q && (key_data == KEY_B);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             reload,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // ">=" rather than "==" so a limit lowered mid-count still expires.
  assign expire_o = en && !reload && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!en || reload || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic svc,
  input  logic expire,
  input  logic clr_flag,
  input  logic clr_fault,
  output logic stage_o,
  output logic irq_o,
  output logic fault_o
);

  logic stage_q;
  logic flag_q;
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= 1'b0;
      flag_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (!en) begin
        stage_q <= 1'b0;
        flag_q  <= 1'b0;
      end else begin
        if (svc) begin
          stage_q <= 1'b0;
        end else if (expire) begin
          stage_q <= 1'b1;
        end
        // A set from an expiry takes priority over a clear on the same clock.
        if (expire) begin
          flag_q <= 1'b1;
        end else if (clr_flag) begin
          flag_q <= 1'b0;
        end
      end
      // expire is already gated by enable, so the fault cannot rise while disabled.
      if (expire && stage_q) begin
        fault_q <= 1'b1;
      end else if (clr_fault) begin
        fault_q <= 1'b0;
      end
    end
  end

  assign stage_o = stage_q;
  assign irq_o   = flag_q;
  assign fault_o = fault_q;

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                CNT_W     = 16,
  parameter logic [CNT_W-1:0]  LIMIT_RST = {CNT_W{1'b1}},
  parameter logic [DATA_W-1:0] KEY_A     = DATA_W'(16'hA602),
  parameter logic [DATA_W-1:0] KEY_B     = DATA_W'(16'hB480)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  irq_o,
  output logic                  fault_o
);

  localparam int LIM_W = (CNT_W < DATA_W) ? CNT_W : DATA_W;

  logic             wr_limit;
  logic             wr_ctrl;
  logic             wr_key;
  logic             wr_clear;
  logic             clr_flag;
  logic             clr_fault;
  logic [CNT_W-1:0] limit_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             svc;
  logic             expire;
  logic             stage_q;

  assign wr_limit  = wr_en && (wr_addr == REG_LIMIT);
  assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign wr_key    = wr_en && (wr_addr == REG_KEY);
  assign wr_clear  = wr_en && (wr_addr == REG_CLEAR);
  assign clr_flag  = wr_clear && wr_data[CLR_FLAG_BIT];
  assign clr_fault = wr_clear && wr_data[CLR_FAULT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= LIMIT_RST;
      en_q    <= 1'b0;
    end else begin
      if (wr_limit) begin
        limit_q <= CNT_W'(wr_data[LIM_W-1:0]);
      end
      if (wr_ctrl) begin
        en_q <= wr_data[CTRL_EN_BIT];
      end
    end
  end

  wdog_key_seq #(
    .DATA_W (DATA_W),
    .KEY_A  (KEY_A),
    .KEY_B  (KEY_B)
  ) u_key (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .key_wr   (wr_key),
    .key_data (wr_data),
    .svc_o    (svc)
  );

  wdog_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .reload   (svc),
    .limit    (limit_q),
    .cnt_o    (cnt_q),
    .expire_o (expire)
  );

  wdog_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .svc       (svc),
    .expire    (expire),
    .clr_flag  (clr_flag),
    .clr_fault (clr_fault),
    .stage_o   (stage_q),
    .irq_o     (irq_o),
    .fault_o   (fault_o)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             svc,
  input logic             expire,
  input logic             stage_q,
  input logic             clr_flag,
  input logic             clr_fault,
  input logic             irq_o,
  input logic             fault_o
);

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == '0));

  assert_first_stage_R3: assert property (@(posedge clk) disable iff (rst)
    (expire && !stage_q && !fault_o && !clr_fault) |=> (irq_o && !fault_o));

  assert_second_stage_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && stage_q) |=> (fault_o && irq_o));

  assert_fault_origin_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(stage_q));

  assert_service_R5: assert property (@(posedge clk) disable iff (rst)
    svc |=> ((cnt_q == '0) && !stage_q));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_flag && !expire) |=> !irq_o);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !clr_fault) |=> fault_o);

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ((cnt_q == '0) && !irq_o && !stage_q));

  assert_disabled_no_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !fault_o) |=> !fault_o);

endmodule

bind wdog_two_stage wdog_checker #(
  .CNT_W (CNT_W)
) u_wdog_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .cnt_q     (cnt_q),
  .svc       (svc),
  .expire    (expire),
  .stage_q   (stage_q),
  .clr_flag  (clr_flag),
  .clr_fault (clr_fault),
  .irq_o     (irq_o),
  .fault_o   (fault_o)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int CNT_W      = 8;
  localparam logic [15:0] KA = 16'hA602;
  localparam logic [15:0] KB = 16'hB480;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              irq_o;
  logic              fault_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    cyc;
    logic  irq;
    logic  flt;
    string tag;
  } exp_t;

  exp_t sb[$];

  wdog_two_stage #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .LIMIT_RST (8'd20)
  ) i_wdog_two_stage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_o   (irq_o),
    .fault_o (fault_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expected output pair for an absolute cycle.
  task automatic expect_at(input int c, input logic irq, input logic flt, input string tag);
    exp_t e;
    e.cyc = c; e.irq = irq; e.flt = flt; e.tag = tag;
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].cyc > c) begin
        sb.insert(i, e);
        return;
      end
    end
    sb.push_back(e);
  endtask

  // Called at a falling edge; the write is captured at the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiesce();
    int t;
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0003);
    t = cyc;
    expect_at(t + 1, 1'b0, 1'b0, "R8 clear after disable");
    wait_to(t + 2);
  endtask

  // Monitor side: compare as the design produces results.
  always @(negedge clk) begin : mon
    exp_t e;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      e = sb.pop_front();
      checks++;
      if (irq_o !== e.irq || fault_o !== e.flt || e.cyc != cyc) begin
        fails++;
        $display("FAIL %s at cycle %0d (due %0d): irq=%b fault=%b expected irq=%b fault=%b",
                 e.tag, cyc, e.cyc, irq_o, fault_o, e.irq, e.flt);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, irq=%b fault=%b expected completion", irq_o, fault_o);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t;
    int e0;
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t = cyc;
    expect_at(t + 1, 1'b0, 1'b0, "R1 reset state");
    wait_to(t + 2);

    // A: reset limit 20 -> period 21; two stages (R1, R2, R3, R4)
    t = cyc; e0 = t + 1;
    expect_at(e0 + 20, 1'b0, 1'b0, "R2 no early expiry");
    expect_at(e0 + 21, 1'b1, 1'b0, "R3 first expiry irq only");
    expect_at(e0 + 41, 1'b1, 1'b0, "R4 before second expiry");
    expect_at(e0 + 42, 1'b1, 1'b1, "R4 second expiry fault");
    wr(2'd1, 16'h0001);
    wait_to(e0 + 43);

    // B: disable keeps fault, clears flag (R8, R9)
    t = cyc;
    expect_at(t + 2, 1'b0, 1'b1, "R9 flag cleared, R8 fault held");
    expect_at(t + 30, 1'b0, 1'b1, "R8 fault held while disabled");
    wr(2'd1, 16'h0000);
    wait_to(t + 31);
    t = cyc;
    expect_at(t + 1, 1'b0, 1'b1, "R8 flag-only clear keeps fault");
    wr(2'd3, 16'h0001);
    t = cyc;
    expect_at(t + 1, 1'b0, 1'b0, "R8 explicit fault clear");
    wr(2'd3, 16'h0002);
    wait_to(t + 2);

    // C: limit 7, W1C, service cancels stage (R10, R2, R7, R5, R4)
    wr(2'd0, 16'h0007);
    t = cyc; e0 = t + 1;
    expect_at(e0 + 7, 1'b0, 1'b0, "R10 R2 no expiry before limit");
    expect_at(e0 + 8, 1'b1, 1'b0, "R10 R2 expiry at new limit");
    expect_at(e0 + 9, 1'b0, 1'b0, "R7 flag write-one-clear");
    wr(2'd1, 16'h0001);
    wait_to(e0 + 8);
    wr(2'd3, 16'h0001);
    wr(2'd2, KA);
    wr(2'd2, KB);
    s = cyc;
    expect_at(s + 7, 1'b0, 1'b0, "R5 count restarted");
    expect_at(s + 8, 1'b1, 1'b0, "R5 stage cancelled, first expiry again");
    expect_at(s + 15, 1'b1, 1'b0, "R4 before second expiry");
    expect_at(s + 16, 1'b1, 1'b1, "R4 second expiry fault");
    wait_to(s + 17);
    quiesce();

    // D/E: bad key orders, zero write, clear then fault (R6, R7, R4)
    t = cyc; e0 = t + 1;
    expect_at(e0 + 7, 1'b0, 1'b0, "R6 no service from bad keys");
    expect_at(e0 + 8, 1'b1, 1'b0, "R6 expiry on original schedule");
    expect_at(e0 + 9, 1'b1, 1'b0, "R7 zero write no effect");
    expect_at(e0 + 10, 1'b0, 1'b0, "R7 flag cleared");
    expect_at(e0 + 15, 1'b0, 1'b0, "R4 before second expiry");
    expect_at(e0 + 16, 1'b1, 1'b1, "R4 second expiry sets flag and fault");
    wr(2'd1, 16'h0001);
    wr(2'd2, KB);
    wr(2'd2, KA);
    wr(2'd2, 16'h1234);
    wr(2'd2, KB);
    wait_to(e0 + 8);
    wr(2'd3, 16'h0000);
    wr(2'd3, 16'h0001);
    wait_to(e0 + 17);
    quiesce();

    // F: clear on the expiry clock loses to the set (R7)
    t = cyc; e0 = t + 1;
    expect_at(e0 + 9, 1'b1, 1'b0, "R7 expiry wins over same-cycle clear");
    wr(2'd1, 16'h0001);
    wait_to(e0 + 7);
    wr(2'd3, 16'h0001);
    wait_to(e0 + 10);
    quiesce();

    // G: disabled mid-count, nothing asserts (R9)
    wr(2'd1, 16'h0001);
    t = cyc;
    wait_to(t + 4);
    s = cyc;
    expect_at(s + 2, 1'b0, 1'b0, "R9 disabled idle");
    expect_at(s + 25, 1'b0, 1'b0, "R9 no expiry while disabled");
    expect_at(s + 60, 1'b0, 1'b0, "R9 no fault while disabled");
    wr(2'd1, 16'h0000);
    wait_to(s + 61);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule